// File: doc/BRIEF.md
# Functional scan test sequencer

This block runs structural test on a small datapath whose registers are linked into one shift chain made from ordinary functional logic rather than dedicated scan cells. During shifting, a masking element ties the side input of each register's next-value logic to zero, so the functional path behaves as a plain transfer. The chain starts at a primary input, passes through an ordered list of registers and ends at an inverting primary output. The example chain included here has `CHAIN_LEN` registers of `DATA_W` bits.

A pattern source delivers one test vector at a time, together with the response it expects, over a valid/ready handshake. The sequencer drives the scan, hold and initialize pins. It loads the first vector and runs one normal-mode capture cycle. It then shifts the captured response out while the next vector shifts in. Every word that leaves the chain is compared with the expected word exactly as supplied, and one pass/fail result is issued per vector. An integrity mode repeats load and unload with no capture, so faults in the chain itself can be found. After the last vector, a final unload with zero input drains the chain, and then the block reports that it is finished.

Top module: `fscan_sequencer`

## Requirements
- R1: While reset is high, and in the idle state after it, the initialize pin is 1 and all chain registers read as zero, so `chainOut` is all ones. `patReady` is 1. `done`, `resValid`, `failFlag` and `mismatchCnt` are 0.
- R2: In a cycle with the scan pin at 1 (hold and initialize at 0), stage 0 takes `chainIn` and each stage k>0 takes the old value of stage k-1. `chainOut` always equals the bitwise inverse of the last stage. Pattern word k (bits k*DATA_W upward of `patVec`) is meant for stage k, and the highest word enters first.
- R3: A capture cycle has scan, hold and initialize all at 0 and `chainIn` at 0. Stage 0 becomes the old value of the last stage plus `chainIn`, modulo 2^DATA_W. Each stage k>0 becomes the XOR of the old values of stages k-1 and k. At most one of the three pins is high in any cycle.
- R4: In normal mode the phase order is as follows: CHAIN_LEN scan cycles to load the first vector, then a capture, then for each later vector CHAIN_LEN scan cycles followed by a capture, then CHAIN_LEN final scan cycles, then done.
- R5: While a response is being unloaded, `chainIn` carries the words of the next vector, highest word first. During the final unload, `chainIn` is zero.
- R6: If the next vector is not offered when it is needed, the block holds the chain: the hold pin is 1, the register contents stay unchanged, and `patReady` stays 1 until the vector is accepted.
- R7: Unloaded word j (j=0 first) is compared directly with expected word CHAIN_LEN-1-j of that vector. The cycle after the last unloaded word, `resValid` pulses for one cycle. `resPass` is 1 only if all words matched, and `resIndex` counts the vectors from 0.
- R8: `failFlag` sets on the first failing vector and stays set. `mismatchCnt` counts failing vectors. Only reset clears either of them.
- R9: `chainCheck` is sampled when the first vector is accepted. In integrity mode no capture cycle ever occurs, so each vector costs CHAIN_LEN cycles. A change on `chainCheck` after the first vector is accepted has no effect.
- R10: A vector is accepted in a cycle where `patValid` and `patReady` are both 1. `patLast` on that vector marks it as the final one.
- R11: After the final unload, `done` is 1 and stays 1, `patReady` is 0, and the hold pin is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chainCheck | input | 1 | 1 selects integrity mode (no capture) |
| patValid | input | 1 | Vector and expected response are offered |
| patReady | output | 1 | Sequencer can take a vector |
| patLast | input | 1 | Offered vector is the final one |
| patVec | input | CHAIN_LEN*DATA_W | Vector, word k for stage k |
| expVec | input | CHAIN_LEN*DATA_W | Expected output words for the vector |
| resValid | output | 1 | One-cycle result pulse |
| resPass | output | 1 | Vector passed |
| resIndex | output | PIDX_W | Index of the reported vector |
| failFlag | output | 1 | Sticky failure flag |
| mismatchCnt | output | CNT_W | Number of failing vectors |
| done | output | 1 | Sequence finished |
| testScan | output | 1 | Scan pin driven to the chain |
| testHold | output | 1 | Hold pin driven to the chain |
| testInit | output | 1 | Initialize pin driven to the chain |
| chainIn | output | DATA_W | Primary input word fed to the chain |
| chainOut | output | DATA_W | Primary output word from the chain |

## Verification
The bench targets these corner cases:
- A vector offered late forces a hold right after capture. A design that shifted or captured through that gap would corrupt the response, and the per-clock chain model flags it on `chainOut`.
- A single-vector run passes from load straight into drain. A design that waited for another vector would never raise `done`.
- Integrity mode must contain no capture at all. Toggling `chainCheck` mid-run must not change the schedule, which shows up in the logged phase string.
- A deliberately corrupted expected word must give exactly one failing result at the right index. A design with an off-by-one word order, a dropped result pulse or a non-sticky flag gives a different result list or counter.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPT,
    ST_WAIT,
    ST_SHIFT,
    ST_DRAIN,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scan;
    logic hold;
    logic init;
    logic takePat;
    logic startDrain;
    logic unloadEn;
    logic useZero;
    logic lastWord;
  } ctrlStrb_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fsq_mask.sv
// force-to-zero element: passes dIn with testPin low, drives zero with testPin high
module fsq_mask #(
  parameter int DATA_W = 8
) (
  input  logic              testPin,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  assign dOut = testPin ? '0 : dIn;
endmodule

// File: rtl/fsq_chain.sv
// example datapath whose registers form a functional shift chain
module fsq_chain #(
  parameter int DATA_W    = 8,
  parameter int CHAIN_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scanPin,
  input  logic              holdPin,
  input  logic              initPin,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  logic [CHAIN_LEN-1:0][DATA_W-1:0] stage;
  logic [CHAIN_LEN-1:0][DATA_W-1:0] sideRaw;
  logic [CHAIN_LEN-1:0][DATA_W-1:0] sideMsk;
  logic [CHAIN_LEN-1:0][DATA_W-1:0] nextVal;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign sideRaw[i] = stage[CHAIN_LEN-1];
      assign nextVal[i] = dataIn + sideMsk[i];
    end else begin : g_body
      assign sideRaw[i] = stage[i];
      assign nextVal[i] = stage[i-1] ^ sideMsk[i];
    end
    fsq_mask #(.DATA_W(DATA_W)) u_mask (
      .testPin(scanPin),
      .dIn    (sideRaw[i]),
      .dOut   (sideMsk[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || initPin) begin
      stage <= '0;
    end else if (!holdPin) begin
      stage <= nextVal;
    end
  end

  assign dataOut = ~stage[CHAIN_LEN-1];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (scanPin && !holdPin && !initPin) |=> (stage[0] == $past(dataIn))); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (holdPin && !initPin) |=> $stable(stage)); // R6

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int CHAIN_LEN = 2,
  parameter int IDX_W     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chainCheck,
  input  logic             patValid,
  input  logic             patLast,
  output logic             patReady,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] wordIdx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

  seqState_t        state, nxtState;
  logic [IDX_W-1:0] cnt;
  logic             integ;
  logic             lastTaken;
  logic             cntLast;
  logic             decide;

  assign cntLast = (cnt == LAST_IDX);
  assign wordIdx = cnt;

  always_comb begin
    strb     = '0;
    patReady = 1'b0;
    done     = 1'b0;
    decide   = 1'b0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        strb.init = 1'b1;
        patReady  = 1'b1;
        if (patValid) begin
          strb.takePat = 1'b1;
          nxtState     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.scan = 1'b1;
        if (cntLast) begin
          if (integ) decide = 1'b1;
          else       nxtState = ST_CAPT;
        end
      end
      ST_CAPT: begin
        decide = 1'b1;
      end
      ST_WAIT: begin
        strb.hold = 1'b1;
        patReady  = 1'b1;
        if (patValid) begin
          strb.takePat = 1'b1;
          nxtState     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        strb.scan     = 1'b1;
        strb.unloadEn = 1'b1;
        strb.lastWord = cntLast;
        if (cntLast) begin
          if (integ) decide = 1'b1;
          else       nxtState = ST_CAPT;
        end
      end
      ST_DRAIN: begin
        strb.scan     = 1'b1;
        strb.unloadEn = 1'b1;
        strb.useZero  = 1'b1;
        strb.lastWord = cntLast;
        if (cntLast) nxtState = ST_DONE;
      end
      ST_DONE: begin
        strb.hold = 1'b1;
        done      = 1'b1;
      end
      default: nxtState = ST_IDLE;
    endcase
    // end of a load or capture: pick drain, overlapped shift or stall
    if (decide) begin
      if (lastTaken) begin
        strb.startDrain = 1'b1;
        nxtState        = ST_DRAIN;
      end else begin
        patReady = 1'b1;
        if (patValid) begin
          strb.takePat = 1'b1;
          nxtState     = ST_SHIFT;
        end else begin
          nxtState = ST_WAIT;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      integ     <= 1'b0;
      lastTaken <= 1'b0;
    end else begin
      state <= nxtState;
      if (strb.scan) cnt <= cntLast ? '0 : cnt + 1'b1;
      else           cnt <= '0;
      if (state == ST_IDLE && strb.takePat) integ <= chainCheck;
      if (strb.takePat) lastTaken <= patLast;
    end
  end

  AST_PIN_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.scan, strb.hold, strb.init}) <= 1); // R3
  AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!strb.scan && !strb.hold && !strb.init) |=> (strb.scan || strb.hold)); // R3
  AST_INTEG_NO_CAPT: assert property (@(posedge clk) disable iff (rst)
    integ |-> (strb.scan || strb.hold || strb.init)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !patReady)); // R11

endmodule

// File: rtl/fsq_datapath.sv
module fsq_datapath
  import fsq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CHAIN_LEN = 2,
  parameter int IDX_W     = 1,
  parameter int PIDX_W    = 8,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrb_t                   strb,
  input  logic [IDX_W-1:0]            wordIdx,
  input  logic [CHAIN_LEN*DATA_W-1:0] patVec,
  input  logic [CHAIN_LEN*DATA_W-1:0] expVec,
  output logic [DATA_W-1:0]           chainIn,
  output logic [DATA_W-1:0]           chainOut,
  output logic                        resValid,
  output logic                        resPass,
  output logic [PIDX_W-1:0]           resIndex,
  output logic                        failFlag,
  output logic [CNT_W-1:0]            mismatchCnt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

  logic [CHAIN_LEN-1:0][DATA_W-1:0] patBuf;
  logic [CHAIN_LEN-1:0][DATA_W-1:0] expPend;
  logic [CHAIN_LEN-1:0][DATA_W-1:0] expUnl;
  logic [IDX_W-1:0]                 selIdx;
  logic                             wordMatch;
  logic                             patOk;
  logic                             vecOk;
  logic [PIDX_W-1:0]                vecCnt;

  assign selIdx    = LAST_IDX - wordIdx;
  assign chainIn   = (strb.scan && !strb.useZero) ? patBuf[selIdx] : '0;
  assign wordMatch = (chainOut == expUnl[selIdx]);
  assign vecOk     = patOk && wordMatch;

  fsq_chain #(.DATA_W(DATA_W), .CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .scanPin(strb.scan),
    .holdPin(strb.hold),
    .initPin(strb.init),
    .dataIn (chainIn),
    .dataOut(chainOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      patBuf      <= '0;
      expPend     <= '0;
      expUnl      <= '0;
      patOk       <= 1'b1;
      vecCnt      <= '0;
      resValid    <= 1'b0;
      resPass     <= 1'b0;
      resIndex    <= '0;
      failFlag    <= 1'b0;
      mismatchCnt <= '0;
    end else begin
      resValid <= 1'b0;
      if (strb.takePat) begin
        patBuf  <= patVec;
        expPend <= expVec;
        expUnl  <= expPend;
      end
      if (strb.startDrain) expUnl <= expPend;
      if (strb.unloadEn) begin
        if (strb.lastWord) begin
          resValid <= 1'b1;
          resPass  <= vecOk;
          resIndex <= vecCnt;
          vecCnt   <= vecCnt + 1'b1;
          patOk    <= 1'b1;
          if (!vecOk) begin
            failFlag <= 1'b1;
            if (mismatchCnt != '1) mismatchCnt <= mismatchCnt + 1'b1;
          end
        end else begin
          patOk <= vecOk;
        end
      end
    end
  end

  AST_RES_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(strb.unloadEn)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    failFlag |=> failFlag); // R8

endmodule

// File: rtl/fscan_sequencer.sv
module fscan_sequencer
  import fsq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CHAIN_LEN = 2,
  parameter int PIDX_W    = 8,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        chainCheck,
  input  logic                        patValid,
  output logic                        patReady,
  input  logic                        patLast,
  input  logic [CHAIN_LEN*DATA_W-1:0] patVec,
  input  logic [CHAIN_LEN*DATA_W-1:0] expVec,
  output logic                        resValid,
  output logic                        resPass,
  output logic [PIDX_W-1:0]           resIndex,
  output logic                        failFlag,
  output logic [CNT_W-1:0]            mismatchCnt,
  output logic                        done,
  output logic                        testScan,
  output logic                        testHold,
  output logic                        testInit,
  output logic [DATA_W-1:0]           chainIn,
  output logic [DATA_W-1:0]           chainOut
);

  localparam int IDX_W = idxWidth(CHAIN_LEN);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] wordIdx;

  fsq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .chainCheck(chainCheck),
    .patValid  (patValid),
    .patLast   (patLast),
    .patReady  (patReady),
    .strb      (strb),
    .wordIdx   (wordIdx),
    .done      (done)
  );

  fsq_datapath #(
    .DATA_W(DATA_W), .CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W),
    .PIDX_W(PIDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wordIdx    (wordIdx),
    .patVec     (patVec),
    .expVec     (expVec),
    .chainIn    (chainIn),
    .chainOut   (chainOut),
    .resValid   (resValid),
    .resPass    (resPass),
    .resIndex   (resIndex),
    .failFlag   (failFlag),
    .mismatchCnt(mismatchCnt)
  );

  assign testScan = strb.scan;
  assign testHold = strb.hold;
  assign testInit = strb.init;

endmodule

// File: tb/fscan_sequencer_test.sv
module fscan_sequencer_test;
  localparam int W = 8;
  localparam int L = 2;
  localparam int PW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          chainCheck = 1'b0;
  logic          patValid = 1'b0;
  logic          patLast = 1'b0;
  logic [L*W-1:0] patVec = '0;
  logic [L*W-1:0] expVec = '0;
  logic          patReady, resValid, resPass, failFlag, done;
  logic          testScan, testHold, testInit;
  logic [PW-1:0] resIndex;
  logic [CW-1:0] mismatchCnt;
  logic [W-1:0]  chainIn, chainOut;

  fscan_sequencer #(.DATA_W(W), .CHAIN_LEN(L), .PIDX_W(PW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .chainCheck(chainCheck), .patValid(patValid),
    .patReady(patReady), .patLast(patLast), .patVec(patVec), .expVec(expVec),
    .resValid(resValid), .resPass(resPass), .resIndex(resIndex),
    .failFlag(failFlag), .mismatchCnt(mismatchCnt), .done(done),
    .testScan(testScan), .testHold(testHold), .testInit(testInit),
    .chainIn(chainIn), .chainOut(chainOut)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit logOn = 1'b0;
  string phaseLog;
  logic [W-1:0] inQ[$];
  logic resPQ[$];
  int resIQ[$];
  logic [W-1:0] mdl [L];
  logic [W-1:0] pw [5][L];
  logic [W-1:0] ew [5][L];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model of the chain, updated from the pins, checked every clock
  always @(negedge clk) begin
    logic [W-1:0] old [L];
    if (cyc > 1) chk(chainOut == ~mdl[L-1], "R2", "chainOut vs model",
                     chainOut, ~mdl[L-1]);
    for (int k = 0; k < L; k++) old[k] = mdl[k];
    if (rst || testInit) begin
      for (int k = 0; k < L; k++) mdl[k] = '0;
    end else if (testHold) begin
      // contents kept
    end else if (testScan) begin
      mdl[0] = chainIn;
      for (int k = 1; k < L; k++) mdl[k] = old[k-1];
    end else begin
      mdl[0] = chainIn + old[L-1];
      for (int k = 1; k < L; k++) mdl[k] = old[k-1] ^ old[k];
    end
    if (logOn && !done && !testInit && !rst) begin
      if (testScan) begin
        phaseLog = {phaseLog, "S"};
        inQ.push_back(chainIn);
      end else if (testHold) phaseLog = {phaseLog, "H"};
      else phaseLog = {phaseLog, "C"};
    end
    if (logOn && resValid) begin
      resPQ.push_back(resPass);
      resIQ.push_back(int'(resIndex));
    end
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finishRun();
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic runScenario(input int n, input bit integ, input int badIdx,
                             input int stallIdx, input bit toggleMode);
    string expPh, filt;
    int hCnt;
    logic [W-1:0] cap [L];
    logic [W-1:0] expIn[$];
    rst = 1'b1;
    patValid = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    chk(testInit == 1'b1, "R1", "init pin in idle", testInit, 1);
    chk(patReady == 1'b1 && done == 1'b0, "R1", "ready/done after reset",
        {patReady, done}, 2);
    chk(failFlag == 1'b0 && mismatchCnt == 0 && resValid == 1'b0, "R1",
        "status after reset", {failFlag, mismatchCnt}, 0);
    chk(chainOut == '1, "R1", "chain cleared", chainOut, 255);
    // build vectors and expected responses from the requirements
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < L; k++) pw[i][k] = W'($urandom);
      if (integ) begin
        for (int k = 0; k < L; k++) ew[i][k] = ~pw[i][k];
      end else begin
        cap[0] = pw[i][L-1];
        for (int k = 1; k < L; k++) cap[k] = pw[i][k-1] ^ pw[i][k];
        for (int k = 0; k < L; k++) ew[i][k] = ~cap[k];
      end
      if (i == badIdx) ew[i][0] = ew[i][0] ^ 8'h01;
    end
    phaseLog = "";
    inQ.delete();
    resPQ.delete();
    resIQ.delete();
    logOn = 1'b1;
    chainCheck = integ;
    for (int i = 0; i < n; i++) begin
      if (i == stallIdx) repeat (4) tick();
      for (int k = 0; k < L; k++) begin
        patVec[k*W +: W] = pw[i][k];
        expVec[k*W +: W] = ew[i][k];
      end
      patLast = (i == n - 1);
      patValid = 1'b1;
      while (patReady !== 1'b1) tick();
      tick();
      patValid = 1'b0;
      if (i == 0 && toggleMode) chainCheck = ~integ;
    end
    while (done !== 1'b1) tick();
    tick();
    logOn = 1'b0;
    // R4 / R9: phase order (hold cycles removed)
    expPh = "";
    for (int k = 0; k < L; k++) expPh = {expPh, "S"};
    for (int i = 0; i < n; i++) begin
      if (!integ) expPh = {expPh, "C"};
      for (int k = 0; k < L; k++) expPh = {expPh, "S"};
    end
    filt = "";
    hCnt = 0;
    for (int c = 0; c < phaseLog.len(); c++) begin
      if (phaseLog[c] == "H") hCnt++;
      else filt = {filt, phaseLog.substr(c, c)};
    end
    checks++;
    if (filt != expPh) begin
      failures++;
      $display("FAIL %s phase order actual=%s expected=%s",
               integ ? "R9" : "R4", filt, expPh);
    end
    // R6: hold only when a vector was late
    if (stallIdx >= 0) chk(hCnt > 0, "R6", "hold cycles during stall", hCnt, 1);
    else chk(hCnt == 0, "R6", "no hold without stall", hCnt, 0);
    // R5: words fed to the chain, then zeros while draining
    for (int i = 0; i < n; i++)
      for (int k = L - 1; k >= 0; k--) expIn.push_back(pw[i][k]);
    for (int k = 0; k < L; k++) expIn.push_back('0);
    chk(inQ.size() == expIn.size(), "R5", "scan input word count",
        inQ.size(), expIn.size());
    for (int j = 0; j < expIn.size() && j < inQ.size(); j++)
      chk(inQ[j] == expIn[j], "R5", "scan input word", inQ[j], expIn[j]);
    // R7: results
    chk(resPQ.size() == n, "R7", "result count", resPQ.size(), n);
    for (int i = 0; i < n && i < resPQ.size(); i++) begin
      chk(resIQ[i] == i, "R7", "result index", resIQ[i], i);
      chk(resPQ[i] == (i != badIdx), "R7", "result pass", resPQ[i], i != badIdx);
    end
    // R8: sticky flag and counter
    chk(failFlag == (badIdx >= 0), "R8", "fail flag", failFlag, badIdx >= 0);
    chk(mismatchCnt == ((badIdx >= 0) ? 1 : 0), "R8", "mismatch count",
        mismatchCnt, (badIdx >= 0) ? 1 : 0);
    // R10 / R11: finished state
    repeat (3) tick();
    chk(done == 1'b1 && patReady == 1'b0, "R11", "done held, not ready",
        {done, patReady}, 2);
    chk(testHold == 1'b1, "R11", "hold pin after done", testHold, 1);
    chk(failFlag == (badIdx >= 0), "R8", "fail flag stays", failFlag, badIdx >= 0);
  endtask

  initial begin
    for (int k = 0; k < L; k++) mdl[k] = '0;
    runScenario(3, 1'b0, -1, -1, 1'b0);  // R3 R4 plain run
    runScenario(3, 1'b0, 1, -1, 1'b1);   // R9 mode change ignored, R7 fail
    runScenario(3, 1'b1, 2, -1, 1'b0);   // R9 integrity mode
    runScenario(2, 1'b0, -1, 1, 1'b0);   // R6 stall before second vector
    runScenario(1, 1'b0, 0, -1, 1'b0);   // R10 single vector with patLast
    finishRun();
  end

endmodule